// File: doc/BRIEF.md
# ASID-Tagged Address Translation Cache

This block is a fully associative cache of completed address translations. Each slot pairs a virtual page with a physical page frame, and carries an 8-bit address space tag, a global marker, a page-size code and a flag field. A request carries a tag and a 32-bit virtual address. One clock later the block answers with either a hit, which returns the physical address and the flags, or a miss, which tells the table walker to fetch the translation. The walker then writes the result through the fill port. One instance serves instruction fetches and a second serves data accesses.

A slot can map a 4 KB, 64 KB, 1 MB or 16 MB page, so one slot covers a large page and the cache holds more of the address space. Fills take a free slot first. When no slot is free, a tree pseudo-LRU chooses the slot to evict. That tree is updated by every hit and by every fill. Two flush controls are provided: one drops every translation, the other drops the non-global translations of one address space. Each takes one cycle.

Top module: `asid_tlb`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and is low otherwise. After reset `rsp_valid`, `rsp_hit` and `rsp_miss` are low.
- R2: When `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is high. On a miss, `rsp_pa` and `rsp_flags` are zero.
- R3: A request hits only when a valid slot has a tag equal to `req_asid` and a virtual page number equal to `req_va[31:12]` in every bit outside the size mask. Otherwise it misses.
- R4: On a hit, `rsp_pa[11:0]` equals `req_va[11:0]`, and `rsp_flags` returns the flags written at fill time.
- R5: A slot filled with `fill_global` high matches a request with any tag value.
- R6: The size code selects the mask: 0 is a 4 KB page with no bits masked, 1 is 64 KB with the low 4 page-number bits masked, 2 is 1 MB with the low 8 masked, and 3 is 16 MB with the low 12 masked. The masked bits are left out of the comparison. In `rsp_pa` those bits are taken from `req_va` in place of the stored frame bits.
- R7: A fill goes to the lowest-numbered invalid slot. When every slot is valid, the fill goes to the victim of a binary tree. The tree has nodes 1..N-1, and the children of node n are 2n (lower half) and 2n+1 (upper half). A node bit of 1 steers the search to the upper child. The tree starts at all zeros. Each hit or fill of slot s points every node on the path of s away from s.
- R8: A cycle with `flush_all` high leaves no valid slot, so every later request misses until the next fill.
- R9: A cycle with `flush_asid_en` high invalidates every non-global slot whose tag equals `flush_asid`. Global slots and slots with other tags keep their translations.
- R10: A fill presented in the same cycle as either flush control is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_asid | input | 8 | Address space tag of the request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Answer for the request of the previous cycle |
| rsp_hit | output | 1 | The translation was found |
| rsp_miss | output | 1 | Not found; the walker should run |
| rsp_pa | output | 32 | Physical address on a hit |
| rsp_flags | output | 8 | Attribute flags on a hit |
| fill_valid | input | 1 | Write a completed translation |
| fill_asid | input | 8 | Tag of the new translation |
| fill_global | input | 1 | New translation matches every tag |
| fill_vpn | input | 20 | Virtual page number |
| fill_size | input | 2 | Page-size code (see R6) |
| fill_ppn | input | 20 | Physical page-frame number |
| fill_flags | input | 8 | Attribute flags |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the non-global slots of one tag |
| flush_asid | input | 8 | Tag targeted by `flush_asid_en` |

## Verification
The bench uses an eight-slot instance. For each page size, lookups sweep all 4096 values of the low twelve page-number bits. This separates bits that must be masked from bits that must still be compared, and it checks that the masked bits of the physical address come from the request. A global slot is looked up with all 256 tag values, and private slots are looked up with wrong tags and with neighbouring pages, which separates tag matching from page matching. Fills into a full cache are interleaved with hits on chosen slots. A tree model kept in the bench predicts each victim, so a wrong eviction order shows up as a missing or surviving translation. Flushes target tags shared by global and private slots, and one flush is raised together with a fill.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int OFS_W = 12;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  // page-number bits that lie inside the page for a given size
  function automatic logic [11:0] low_mask(input pg_size_e sz);
    case (sz)
      PG_64K:  return 12'h00F;
      PG_1M:   return 12'h0FF;
      PG_16M:  return 12'hFFF;
      default: return 12'h000;
    endcase
  endfunction

endpackage

// File: rtl/asid_tlb_match.sv
module asid_tlb_match
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0]             ent_global,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][1:0]        ent_size,
  input  logic [ASID_W-1:0]              key_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  output logic [ENTRIES-1:0]             match_vec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [VPN_W-1:0] care;
    logic             tag_ok;
    assign care     = ~VPN_W'(low_mask(pg_size_e'(ent_size[i])));
    assign tag_ok   = ent_global[i] || (ent_asid[i] == key_asid);
    assign match_vec[i] = ent_valid[i] && tag_ok &&
                          (((ent_vpn[i] ^ key_vpn) & care) == '0);
  end

endmodule

// File: rtl/asid_tlb_plru.sv
module asid_tlb_plru #(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  // node n (1..ENTRIES-1) is stored at bit n-1; 1 steers toward the upper child
  logic [ENTRIES-2:0] tree_q;

  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < IDX_W; l++) begin
      node = 2 * node + int'(tree_q[node-1]);
    end
    victim_idx = IDX_W'(node - ENTRIES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tree_q <= '0;
    end else if (touch_en) begin
      for (int l = 0; l < IDX_W; l++) begin
        tree_q[(1 << l) + int'(touch_idx >> (IDX_W - l)) - 1] <= ~touch_idx[IDX_W-1-l];
      end
    end
  end

endmodule

// File: rtl/asid_tlb_pick.sv
module asid_tlb_pick #(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   aged_idx,
  output logic [IDX_W-1:0]   slot_idx,
  output logic               slot_free
);

  always_comb begin
    slot_free = 1'b0;
    slot_idx  = aged_idx;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        slot_free = 1'b1;
        slot_idx  = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int ASID_W  = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int FLAG_W  = 8,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [FLAG_W-1:0] rsp_flags,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [1:0]        fill_size,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [FLAG_W-1:0] fill_flags,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0]             ent_global;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][1:0]        ent_size;
  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
  logic [ENTRIES-1:0][FLAG_W-1:0] ent_flags;

  // named internal events
  logic [ENTRIES-1:0] lookup_match;
  logic               lookup_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               flush_any;
  logic               fill_take;
  logic [IDX_W-1:0]   fill_slot;
  logic               fill_slot_free;
  logic [IDX_W-1:0]   aged_idx;
  logic               touch_en;
  logic [IDX_W-1:0]   touch_idx;

  logic [VPN_W-1:0]   req_vpn;
  logic [PPN_W-1:0]   sel_mask;
  logic [PPN_W-1:0]   pa_frame;

  assign req_vpn = req_va[VA_W-1:OFS_W];

  asid_tlb_match #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)
  ) u_match (
    .ent_valid (ent_valid),
    .ent_global(ent_global),
    .ent_asid  (ent_asid),
    .ent_vpn   (ent_vpn),
    .ent_size  (ent_size),
    .key_asid  (req_asid),
    .key_vpn   (req_vpn),
    .match_vec (lookup_match)
  );

  assign lookup_hit = |lookup_match;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookup_match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign sel_mask = PPN_W'(low_mask(pg_size_e'(ent_size[hit_idx])));
  assign pa_frame = (ent_ppn[hit_idx] & ~sel_mask) | (PPN_W'(req_vpn) & sel_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_flags <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lookup_hit;
      rsp_miss  <= req_valid && !lookup_hit;
      rsp_pa    <= (req_valid && lookup_hit) ? {pa_frame, req_va[OFS_W-1:0]} : '0;
      rsp_flags <= (req_valid && lookup_hit) ? ent_flags[hit_idx] : '0;
    end
  end

  // replacement
  assign flush_any = flush_all || flush_asid_en;
  assign fill_take = fill_valid && !flush_any;
  assign touch_en  = fill_take || (req_valid && lookup_hit);
  assign touch_idx = fill_take ? fill_slot : hit_idx;

  asid_tlb_plru #(.ENTRIES(ENTRIES)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim_idx(aged_idx)
  );

  asid_tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .valid_vec(ent_valid),
    .aged_idx (aged_idx),
    .slot_idx (fill_slot),
    .slot_free(fill_slot_free)
  );

  // slot storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
    end else if (flush_all) begin
      ent_valid <= '0;
    end else if (flush_asid_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!ent_global[i] && ent_asid[i] == flush_asid) ent_valid[i] <= 1'b0;
      end
    end else if (fill_take) begin
      ent_valid[fill_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_take) begin
      ent_global[fill_slot] <= fill_global;
      ent_asid[fill_slot]   <= fill_asid;
      ent_vpn[fill_slot]    <= fill_vpn;
      ent_size[fill_slot]   <= fill_size;
      ent_ppn[fill_slot]    <= fill_ppn;
      ent_flags[fill_slot]  <= fill_flags;
    end
  end

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
  parameter int ENTRIES = 128,
  parameter int ASID_W  = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int FLAG_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic [VA_W-1:0]              req_va,
  input logic                         rsp_valid,
  input logic                         rsp_hit,
  input logic                         rsp_miss,
  input logic [PA_W-1:0]              rsp_pa,
  input logic [FLAG_W-1:0]            rsp_flags,
  input logic                         flush_all,
  input logic                         flush_asid_en,
  input logic [ASID_W-1:0]            flush_asid,
  input logic [ENTRIES-1:0]           ent_valid,
  input logic [ENTRIES-1:0]           ent_global,
  input logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input logic [ENTRIES-1:0]           lookup_match,
  input logic                         fill_take,
  input logic [IDX_W-1:0]             fill_slot
);

  logic              asid_flush_q;
  logic [ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0] stale_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asid_flush_q <= 1'b0;
      asid_q       <= '0;
    end else begin
      asid_flush_q <= flush_asid_en && !flush_all;
      asid_q       <= flush_asid;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      stale_vec[i] = ent_valid[i] && !ent_global[i] && (ent_asid[i] == asid_q);
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss)); // R2
  AST_NO_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0 && rsp_flags == '0)); // R2
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lookup_match)); // R3
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_pa[11:0] == $past(req_va[11:0]))); // R4
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_take && !(&ent_valid)) |-> !ent_valid[fill_slot]); // R7
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_take |=> ent_valid[$past(fill_slot)]); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_valid == '0)); // R8
  AST_ASID_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    asid_flush_q |-> (stale_vec == '0)); // R9
  AST_FLUSH_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !fill_take); // R10

endmodule

bind asid_tlb asid_tlb_checker #(
  .ENTRIES(ENTRIES), .ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_va       (req_va),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_pa       (rsp_pa),
  .rsp_flags    (rsp_flags),
  .flush_all    (flush_all),
  .flush_asid_en(flush_asid_en),
  .flush_asid   (flush_asid),
  .ent_valid    (ent_valid),
  .ent_global   (ent_global),
  .ent_asid     (ent_asid),
  .lookup_match (lookup_match),
  .fill_take    (fill_take),
  .fill_slot    (fill_slot)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_asid = '0;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_pa;
  logic [7:0]  rsp_flags;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_asid = '0;
  logic        fill_global = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [1:0]  fill_size = '0;
  logic [19:0] fill_ppn = '0;
  logic [7:0]  fill_flags = '0;
  logic        flush_all = 1'b0;
  logic        flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;

  always #2.5 clk = ~clk;

  asid_tlb #(.ENTRIES(N)) u_asid_tlb (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side model of slots and of the aging tree
  bit        m_v [N];
  bit        m_g [N];
  bit [7:0]  m_a [N];
  bit [19:0] m_vpn [N];
  int        m_sz [N];
  bit [19:0] m_ppn [N];
  bit [7:0]  m_fl [N];
  bit        m_t [N];

  function automatic bit [19:0] span(input int sz);
    return 20'((1 << (4 * sz)) - 1);
  endfunction

  function automatic void touch(input int s);
    int n;
    n = s + N;
    while (n > 1) begin
      m_t[n / 2] = (n % 2 == 0);
      n = n / 2;
    end
  endfunction

  function automatic int pick_slot();
    int n;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    n = 1;
    while (n < N) n = 2 * n + int'(m_t[n]);
    return n - N;
  endfunction

  task automatic result(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  task automatic look(input bit [7:0] a, input bit [31:0] va, input string tag);
    bit        eh = 0;
    int        es = 0;
    bit [31:0] epa = '0;
    bit [7:0]  efl = '0;
    bit [19:0] m;
    bit        ok;
    for (int i = 0; i < N; i++) begin
      m = span(m_sz[i]);
      if (!eh && m_v[i] && (m_g[i] || m_a[i] == a) && (((m_vpn[i] ^ va[31:12]) & ~m) == '0)) begin
        eh = 1; es = i;
        epa = {(m_ppn[i] & ~m) | (va[31:12] & m), va[11:0]};
        efl = m_fl[i];
      end
    end
    @(negedge clk);
    req_valid = 1; req_asid = a; req_va = va;
    @(negedge clk);
    req_valid = 0;
    ok = rsp_valid && rsp_hit == eh && rsp_miss == !eh && rsp_pa == epa && rsp_flags == efl;
    result(ok, tag, $sformatf("asid=%0h va=%08h got v=%0b h=%0b m=%0b pa=%08h fl=%02h exp h=%0b pa=%08h fl=%02h",
           a, va, rsp_valid, rsp_hit, rsp_miss, rsp_pa, rsp_flags, eh, epa, efl));
    if (eh) touch(es);
  endtask

  task automatic put(input bit [7:0] a, input bit g, input bit [19:0] vpn, input int sz,
                     input bit [19:0] ppn, input bit [7:0] fl, input bit fa, input bit fae,
                     input bit [7:0] fasid);
    int s;
    @(negedge clk);
    fill_valid = 1; fill_asid = a; fill_global = g; fill_vpn = vpn;
    fill_size = 2'(sz); fill_ppn = ppn; fill_flags = fl;
    flush_all = fa; flush_asid_en = fae; flush_asid = fasid;
    @(negedge clk);
    fill_valid = 0; flush_all = 0; flush_asid_en = 0;
    if (fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fae) begin
      for (int i = 0; i < N; i++) if (!m_g[i] && m_a[i] == fasid) m_v[i] = 0;
    end else begin
      s = pick_slot();
      m_v[s] = 1; m_g[s] = g; m_a[s] = a; m_vpn[s] = vpn;
      m_sz[s] = sz; m_ppn[s] = ppn; m_fl[s] = fl;
      touch(s);
    end
  endtask

  task automatic flush(input bit fa, input bit [7:0] fasid);
    @(negedge clk);
    flush_all = fa; flush_asid_en = !fa; flush_asid = fasid;
    @(negedge clk);
    flush_all = 0; flush_asid_en = 0;
    for (int i = 0; i < N; i++)
      if (fa || (!m_g[i] && m_a[i] == fasid)) m_v[i] = 0;
  endtask

  task automatic verify_all(input string tag);
    for (int i = 0; i < N; i++) begin
      bit [7:0]  a = m_a[i];
      bit [19:0] v = m_vpn[i];
      look(a, {v, 12'h5A5}, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_a[i] = 0; m_vpn[i] = 0;
      m_sz[i] = 0; m_ppn[i] = 0; m_fl[i] = 0; m_t[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet after reset
    result(!rsp_valid && !rsp_hit && !rsp_miss, "R1",
           $sformatf("reset v=%0b h=%0b m=%0b exp 0 0 0", rsp_valid, rsp_hit, rsp_miss));
    // R2: empty cache misses
    look(8'h01, 32'h1000_0123, "R2");
    @(negedge clk);
    result(!rsp_valid, "R1", $sformatf("idle rsp_valid=%0b exp 0", rsp_valid));

    // R3/R4: four private 4K pages
    for (int k = 0; k < 4; k++)
      put(8'h01, 0, 20'h10000 + 20'(k), 0, 20'h80000 + 20'(3 * k), 8'(8'h10 + k), 0, 0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      look(8'h01, {20'h10000 + 20'(k), 12'h000}, "R4");
      look(8'h01, {20'h10000 + 20'(k), 12'h7FF}, "R4");
      look(8'h01, {20'h10000 + 20'(k), 12'hFFF}, "R4");
      look(8'h02, {20'h10000 + 20'(k), 12'h001}, "R3");
      look(8'h81, {20'h10000 + 20'(k), 12'h001}, "R3");
    end
    look(8'h01, {20'h10004, 12'h000}, "R3");
    look(8'h01, {20'h18000, 12'h000}, "R3");

    // R5: global page, every tag
    put(8'h09, 1, 20'h05000, 0, 20'h0ABCD, 8'hC3, 0, 0, 8'h00);
    for (int a = 0; a < 256; a++) look(8'(a), {20'h05000, 12'h321}, "R5");

    // R6: larger pages with junk in the masked stored bits
    put(8'h02, 0, 20'h20037, 1, 20'h9ABCD, 8'h64, 0, 0, 8'h00);
    put(8'h01, 0, 20'h30ABC, 2, 20'h7F0F0, 8'h65, 0, 0, 8'h00);
    put(8'h01, 1, 20'h40123, 3, 20'h55555, 8'h66, 0, 0, 8'h00);
    for (int d = 0; d < 4096; d++) begin
      look(8'h02, {20'h20000 | 20'(d), 12'h0C4}, "R6");
      look(8'h01, {20'h30000 | 20'(d), 12'h0C5}, "R6");
      look(8'h33, {20'h40000 | 20'(d), 12'h0C6}, "R6");
    end
    look(8'h03, {20'h20030, 12'h000}, "R6");

    // R7: eviction order in a full cache
    for (int k = 0; k < 12; k++) begin
      bit [7:0]  ea;
      bit [19:0] ev;
      int        vs;
      look(m_a[(k * 3) % N], {m_vpn[(k * 3) % N], 12'h010}, "R7");
      look(m_a[(k * 5 + 1) % N], {m_vpn[(k * 5 + 1) % N], 12'h020}, "R7");
      vs = pick_slot();
      ea = m_a[vs];
      ev = m_vpn[vs];
      put(8'h03, 0, 20'h60000 + 20'(k), 0, 20'h61000 + 20'(k), 8'(k), 0, 0, 8'h00);
      look(ea, {ev, 12'h000}, "R7");
      verify_all("R7");
    end

    // R9: tag flush keeps globals and other tags
    put(8'h03, 1, 20'h70000, 0, 20'h71000, 8'hA1, 0, 0, 8'h00);
    put(8'h04, 0, 20'h70001, 0, 20'h71001, 8'hA2, 0, 0, 8'h00);
    put(8'h03, 0, 20'h70002, 1, 20'h71002, 8'hA3, 0, 0, 8'h00);
    flush(0, 8'h03);
    look(8'h03, {20'h70000, 12'h000}, "R9");
    look(8'h04, {20'h70001, 12'h000}, "R9");
    look(8'h03, {20'h70002, 12'h000}, "R9");
    for (int k = 0; k < 12; k++) look(8'h03, {20'h60000 + 20'(k), 12'h000}, "R9");
    verify_all("R9");

    // R10: fill together with a flush is dropped
    put(8'h05, 0, 20'h7A000, 0, 20'h7B000, 8'hEE, 0, 1, 8'h77);
    look(8'h05, {20'h7A000, 12'h000}, "R10");
    put(8'h05, 0, 20'h7A001, 0, 20'h7B001, 8'hEF, 1, 0, 8'h00);
    look(8'h05, {20'h7A001, 12'h000}, "R10");

    // R8: full flush
    put(8'h06, 1, 20'h7C000, 0, 20'h7D000, 8'h11, 0, 0, 8'h00);
    flush(1, 8'h00);
    look(8'h06, {20'h7C000, 12'h000}, "R8");
    look(8'h04, {20'h70001, 12'h000}, "R8");
    put(8'h06, 0, 20'h7C001, 0, 20'h7D001, 8'h12, 0, 0, 8'h00);
    look(8'h06, {20'h7C001, 12'h abc}, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule